// File: doc/BRIEF.md
# Adaptive-Precision Ternary Serial Codec

This block moves fractional fixed-point values across a narrow link as a variable-length stream of digits, most significant first. Every digit is one of three symbols, zero, one or end-of-number, so a number occupies only as many digit slots as it has significant digits plus one closing marker. A short number costs few link cycles and little switching activity, while a precise one costs more.

The transmit side accepts a fraction and a precision request through a valid/ready load. It keeps no more leading digits than the request asks for, drops the zeros that trail the last one digit, and streams the rest, one digit per clock, followed by the end marker. The receive side rebuilds the fraction with the received digits at the top bit positions and zeros below them. On the end marker it presents the value and the number of digits it received, with a one-cycle done pulse. The two halves share only the clock and reset, so the link can be looped back, or the two halves can face separate peers.

Encoder states: `ENC_IDLE` (ready, waiting for a load), `ENC_SEND` (one data digit per cycle) and `ENC_TERM` (end marker). Transitions: `ENC_IDLE -> ENC_SEND` on a load with at least one kept digit; `ENC_IDLE -> ENC_TERM` on a load with no kept digit; `ENC_SEND -> ENC_SEND` while more than one digit remains; `ENC_SEND -> ENC_TERM` after the last kept digit; `ENC_TERM -> ENC_IDLE` always. Decoder states: `DEC_EMPTY` (no digit of the current number yet) and `DEC_FILL` (digits collected). Transitions: `DEC_EMPTY -> DEC_FILL` on a data digit; `DEC_FILL -> DEC_FILL` on further data digits; any state `-> DEC_EMPTY` on an end marker or an illegal code.

Top module: `ternary_serial_codec`

## Requirements
- R1: On the two-wire channel a digit is coded 2'b00 = zero, 2'b01 = one, 2'b10 = end of number; the encoder never drives 2'b11 while `tx_dig_vld` is high.
- R2: `tx_ready` is high only while the encoder is idle. A load is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from that edge until the edge after the end marker has been sent.
- R3: Data digits go out most significant first: digit j of a number is bit (FRAC_W-1-j) of `tx_frac`, with digit 0 in the first cycle after the load.
- R4: Only the top min(`tx_prec`, FRAC_W) bits of `tx_frac` are considered; lower bits have no effect on the stream, and a request larger than FRAC_W acts as FRAC_W.
- R5: Zeros after the last one digit inside the requested precision are not sent. The end marker follows the last one digit in the next cycle, and a number with k kept digits occupies exactly k+1 consecutive cycles with `tx_dig_vld` high.
- R6: A value with no one digit inside the requested precision, including a request of 0, is sent as a lone end marker and decodes to value 0 with count 0.
- R7: When the decoder samples an end marker, `rx_done` is high for exactly the next cycle. `rx_value` then holds the received digits at the top bit positions in arrival order with all lower bits zero, and it keeps that value until the next end marker.
- R8: `rx_count` reports the number of data digits received for the completed number.
- R9: A sampled code 2'b11 makes `rx_err` high for exactly the next cycle, discards the partial number without a done pulse, and the following number decodes as if nothing had arrived before it.
- R10: Data digits beyond FRAC_W in one number are dropped; the decoded value keeps the first FRAC_W digits and `rx_count` saturates at FRAC_W.
- R11: After reset `tx_ready` = 1, `tx_dig_vld` = 0, `rx_done` = 0, `rx_err` = 0, `rx_value` = 0 and `rx_count` = 0.
- R12: The decoder ignores `rx_dig` in cycles where `rx_dig_vld` is low, whatever the code on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Load request for a new number |
| tx_ready | output | 1 | Encoder idle and able to take a load |
| tx_frac | input | FRAC_W | Fraction to send, MSB weighs one half |
| tx_prec | input | PREC_W | Maximum number of data digits requested |
| tx_dig | output | 2 | Digit code driven onto the link |
| tx_dig_vld | output | 1 | A digit is present on `tx_dig` this cycle |
| rx_dig | input | 2 | Digit code arriving from the link |
| rx_dig_vld | input | 1 | A digit is present on `rx_dig` this cycle |
| rx_value | output | FRAC_W | Last completed fraction, zero-filled |
| rx_count | output | PREC_W | Data digits in the last completed fraction |
| rx_done | output | 1 | One-cycle pulse when a number completes |
| rx_err | output | 1 | One-cycle pulse on an illegal code |

## Verification
The encoder checks take for granted that `tx_frac` and `tx_prec` stay steady while `tx_valid` waits for `tx_ready`. The bench drives them at a falling edge together with `tx_valid` and lowers `tx_valid` right after the accepting edge. The decoder checks take nothing about the order of codes, since illegal codes, overlong numbers and idle cycles carrying junk are all defined behaviour. The stimulus deliberately mixes looped-back encoder traffic with hand-built streams that contain each of these, and every hand-built digit is held for exactly one clock.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_ONE  = 2'b01,
        DIG_END  = 2'b10,
        DIG_BAD  = 2'b11
    } digit_e;

    typedef enum logic [1:0] {
        ENC_IDLE = 2'b00,
        ENC_SEND = 2'b01,
        ENC_TERM = 2'b10
    } enc_state_e;

    typedef enum logic {
        DEC_EMPTY = 1'b0,
        DEC_FILL  = 1'b1
    } dec_state_e;

endpackage

// File: rtl/tsc_trim.sv
module tsc_trim #(
    parameter int FRAC_W = 8,
    parameter int PREC_W = $clog2(FRAC_W + 1)
) (
    input  logic [FRAC_W-1:0] frac,
    input  logic [PREC_W-1:0] prec,
    output logic [PREC_W-1:0] kept,
    output logic [FRAC_W-1:0] trimmed
);
    localparam logic [FRAC_W-1:0] ALL_ONES = {FRAC_W{1'b1}};

    int lim_i;
    int keep_i;

    // Digits considered: the top min(prec, FRAC_W); the kept run ends at the last one.
    always_comb begin
        lim_i  = (int'(prec) > FRAC_W) ? FRAC_W : int'(prec);
        keep_i = 0;
        for (int i = 0; i < FRAC_W; i++) begin
            if (i < lim_i && frac[FRAC_W-1-i]) begin
                keep_i = i + 1;
            end
        end
        kept    = PREC_W'(keep_i);
        trimmed = frac & ~(ALL_ONES >> keep_i);
    end

endmodule

// File: rtl/tsc_encoder.sv
module tsc_encoder
    import tsc_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int PREC_W = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [PREC_W-1:0] load_kept,
    input  logic [FRAC_W-1:0] load_bits,
    output logic              load_ready,
    output logic [1:0]        dig,
    output logic              dig_vld
);
    localparam logic [PREC_W-1:0] ONE_LEFT = PREC_W'(1);

    enc_state_e        state_q, state_d;
    logic [FRAC_W-1:0] shreg_q;
    logic [PREC_W-1:0] rem_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_IDLE: begin
                if (load_valid) begin
                    state_d = (load_kept == '0) ? ENC_TERM : ENC_SEND;
                end
            end
            ENC_SEND: begin
                if (rem_q == ONE_LEFT) begin
                    state_d = ENC_TERM;
                end
            end
            ENC_TERM: state_d = ENC_IDLE;
            default:  state_d = ENC_IDLE;
        endcase
    end

    // State register with its data path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENC_IDLE;
            shreg_q <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ENC_IDLE: begin
                    if (load_valid) begin
                        shreg_q <= load_bits;
                        rem_q   <= load_kept;
                    end
                end
                ENC_SEND: begin
                    shreg_q <= shreg_q << 1;
                    rem_q   <= rem_q - ONE_LEFT;
                end
                default: ;
            endcase
        end
    end

    // Outputs from the current state.
    always_comb begin
        load_ready = 1'b0;
        dig_vld    = 1'b0;
        dig        = DIG_ZERO;
        unique case (state_q)
            ENC_IDLE: load_ready = 1'b1;
            ENC_SEND: begin
                dig_vld = 1'b1;
                dig     = shreg_q[FRAC_W-1] ? DIG_ONE : DIG_ZERO;
            end
            ENC_TERM: begin
                dig_vld = 1'b1;
                dig     = DIG_END;
            end
            default: ;
        endcase
    end

    assert_no_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dig_vld |-> (dig != DIG_BAD));

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_ready) |-> $past(load_valid));

    assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_vld && dig == DIG_END) |=> load_ready);

    assert_last_is_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_SEND && rem_q == ONE_LEFT) |-> shreg_q[FRAC_W-1]);

    assert_end_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENC_SEND && rem_q == ONE_LEFT) |=> (dig_vld && dig == DIG_END));

endmodule

// File: rtl/tsc_decoder.sv
module tsc_decoder
    import tsc_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int PREC_W = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dig_vld,
    input  logic [1:0]        dig,
    output logic [FRAC_W-1:0] value,
    output logic [PREC_W-1:0] count,
    output logic              done,
    output logic              err
);
    localparam logic [FRAC_W-1:0] TOP_BIT = {1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [PREC_W-1:0] FULL    = PREC_W'(FRAC_W);

    dec_state_e        state_q;
    logic [FRAC_W-1:0] acc_q;
    logic [PREC_W-1:0] cnt_q;
    logic [FRAC_W-1:0] value_q;
    logic [PREC_W-1:0] count_q;
    logic              done_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_EMPTY;
            acc_q   <= '0;
            cnt_q   <= '0;
            value_q <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (dig_vld) begin
                unique case (digit_e'(dig))
                    DIG_ZERO, DIG_ONE: begin
                        state_q <= DEC_FILL;
                        if (cnt_q < FULL) begin
                            if (dig == DIG_ONE) begin
                                acc_q <= acc_q | (TOP_BIT >> cnt_q);
                            end
                            cnt_q <= cnt_q + PREC_W'(1);
                        end
                    end
                    DIG_END: begin
                        state_q <= DEC_EMPTY;
                        value_q <= acc_q;
                        count_q <= cnt_q;
                        done_q  <= 1'b1;
                        acc_q   <= '0;
                        cnt_q   <= '0;
                    end
                    DIG_BAD: begin
                        state_q <= DEC_EMPTY;
                        err_q   <= 1'b1;
                        acc_q   <= '0;
                        cnt_q   <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        value = value_q;
        count = count_q;
        done  = done_q;
        err   = err_q;
    end

    assert_bad_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_vld && dig == DIG_BAD) |=> (err && !done));

    assert_end_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_vld && dig == DIG_END) |=> (done && !err));

    assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((value << count) == '0));

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count <= FULL));

    assert_fill_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DEC_EMPTY) |-> (cnt_q == '0));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dig_vld |=> (!done && !err && $stable(cnt_q)));

endmodule

// File: rtl/ternary_serial_codec.sv
module ternary_serial_codec #(
    parameter int FRAC_W = 8,
    parameter int PREC_W = $clog2(FRAC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [FRAC_W-1:0] tx_frac,
    input  logic [PREC_W-1:0] tx_prec,
    output logic [1:0]        tx_dig,
    output logic              tx_dig_vld,
    input  logic [1:0]        rx_dig,
    input  logic              rx_dig_vld,
    output logic [FRAC_W-1:0] rx_value,
    output logic [PREC_W-1:0] rx_count,
    output logic              rx_done,
    output logic              rx_err
);
    logic [PREC_W-1:0] kept;
    logic [FRAC_W-1:0] trimmed;

    tsc_trim #(.FRAC_W(FRAC_W), .PREC_W(PREC_W)) u_trim (
        .frac    (tx_frac),
        .prec    (tx_prec),
        .kept    (kept),
        .trimmed (trimmed)
    );

    tsc_encoder #(.FRAC_W(FRAC_W), .PREC_W(PREC_W)) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (tx_valid),
        .load_kept  (kept),
        .load_bits  (trimmed),
        .load_ready (tx_ready),
        .dig        (tx_dig),
        .dig_vld    (tx_dig_vld)
    );

    tsc_decoder #(.FRAC_W(FRAC_W), .PREC_W(PREC_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .dig_vld (rx_dig_vld),
        .dig     (rx_dig),
        .value   (rx_value),
        .count   (rx_count),
        .done    (rx_done),
        .err     (rx_err)
    );

endmodule

// File: tb/ternary_serial_codec_tb.sv
`timescale 1ns/1ps
module ternary_serial_codec_tb;
    localparam int W  = 8;
    localparam int PW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [W-1:0]  tx_frac = '0;
    logic [PW-1:0] tx_prec = '0;
    logic [1:0]    tx_dig;
    logic          tx_dig_vld;
    logic          loop_sel = 1'b1;
    logic [1:0]    drv_dig = 2'b00;
    logic          drv_vld = 1'b0;
    logic [1:0]    rx_dig;
    logic          rx_dig_vld;
    logic [W-1:0]  rx_value;
    logic [PW-1:0] rx_count;
    logic          rx_done;
    logic          rx_err;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    assign rx_dig     = loop_sel ? tx_dig : drv_dig;
    assign rx_dig_vld = loop_sel ? tx_dig_vld : drv_vld;

    ternary_serial_codec #(.FRAC_W(W), .PREC_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_frac(tx_frac), .tx_prec(tx_prec),
        .tx_dig(tx_dig), .tx_dig_vld(tx_dig_vld),
        .rx_dig(rx_dig), .rx_dig_vld(rx_dig_vld),
        .rx_value(rx_value), .rx_count(rx_count), .rx_done(rx_done), .rx_err(rx_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 tx_ready", 32'(tx_ready), 1);
        chk("R11 tx_dig_vld", 32'(tx_dig_vld), 0);
        chk("R11 rx_done", 32'(rx_done), 0);
        chk("R11 rx_err", 32'(rx_err), 0);
        chk("R11 rx_value", 32'(rx_value), 0);
        chk("R11 rx_count", 32'(rx_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Looped-back transfer: expected stream, value and count follow R3-R8.
    task automatic t_send(input logic [W-1:0] f, input int p, input string tag);
        int lim;
        int kept;
        int n;
        bit seen;
        logic [W-1:0] ev;
        logic [1:0] got [16];
        lim = (p > W) ? W : p;
        kept = 0;
        n = 0;
        seen = 0;
        ev = '0;
        for (int j = 0; j < lim; j++) if (f[W-1-j]) kept = j + 1;
        for (int j = 0; j < kept; j++) ev[W-1-j] = f[W-1-j];
        for (int j = 0; j < 16; j++) got[j] = 2'b00;
        @(negedge clk);
        loop_sel = 1'b1;
        tx_frac = f;
        tx_prec = PW'(p);
        tx_valid = 1'b1;
        chk({tag, " R2 ready before load"}, 32'(tx_ready), 1);
        @(negedge clk);
        tx_valid = 1'b0;
        chk({tag, " R2 ready after load"}, 32'(tx_ready), 0);
        for (int c = 0; c < 24; c++) begin
            if (tx_dig_vld) begin
                if (n < 16) got[n] = tx_dig;
                n++;
                chk({tag, " R2 busy"}, 32'(tx_ready), 0);
            end
            if (rx_done) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
        chk({tag, " R7 done seen"}, 32'(seen), 1);
        chk({tag, " R5 digit cycles"}, 32'(n), 32'(kept + 1));
        for (int j = 0; j < kept && j < 16; j++)
            chk({tag, " R3 digit"}, 32'(got[j]), f[W-1-j] ? 32'h1 : 32'h0);
        if (kept < 16) chk({tag, " R1 end code"}, 32'(got[kept]), 32'h2);
        chk({tag, " R7 value"}, 32'(rx_value), 32'(ev));
        chk({tag, " R8 count"}, 32'(rx_count), 32'(kept));
        chk({tag, " R2 ready again"}, 32'(tx_ready), 1);
        @(negedge clk);
        chk({tag, " R7 done one cycle"}, 32'(rx_done), 0);
        chk({tag, " R7 value held"}, 32'(rx_value), 32'(ev));
    endtask

    task automatic put(input logic [1:0] d);
        @(negedge clk);
        loop_sel = 1'b0;
        drv_vld = 1'b1;
        drv_dig = d;
    endtask

    task automatic hush(input logic [1:0] junk);
        @(negedge clk);
        loop_sel = 1'b0;
        drv_vld = 1'b0;
        drv_dig = junk;
    endtask

    task automatic t_illegal();
        put(2'b01); put(2'b01); put(2'b11);
        hush(2'b00);
        chk("R9 err pulse", 32'(rx_err), 1);
        chk("R9 no done", 32'(rx_done), 0);
        hush(2'b00);
        chk("R9 err one cycle", 32'(rx_err), 0);
        put(2'b00); put(2'b01); put(2'b10);
        hush(2'b00);
        chk("R9 clean done", 32'(rx_done), 1);
        chk("R9 clean value", 32'(rx_value), 32'h40);
        chk("R9 clean count", 32'(rx_count), 2);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < W; i++) put(2'b01);
        put(2'b01); put(2'b00);
        put(2'b10);
        hush(2'b00);
        chk("R10 done", 32'(rx_done), 1);
        chk("R10 value", 32'(rx_value), 32'hFF);
        chk("R10 count", 32'(rx_count), 32'(W));
    endtask

    task automatic t_gaps();
        put(2'b01);
        hush(2'b11);
        chk("R12 no err", 32'(rx_err), 0);
        hush(2'b10);
        chk("R12 no done", 32'(rx_done), 0);
        hush(2'b01);
        put(2'b00); put(2'b01); put(2'b10);
        hush(2'b11);
        chk("R12 done", 32'(rx_done), 1);
        chk("R12 value", 32'(rx_value), 32'hA0);
        chk("R12 count", 32'(rx_count), 3);
        hush(2'b11);
        chk("R12 idle no err", 32'(rx_err), 0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_send(8'b1011_0000, 8, "basic");
        t_send(8'b1111_1111, 3, "R4 short request");
        t_send(8'b1010_0101, 5, "R5 trim");
        t_send(8'b0000_0001, 8, "full length");
        t_send(8'b0000_0001, 15, "R4 oversize request");
        t_send(8'b1111_1111, 8, "all ones");
        t_send(8'b0000_0000, 8, "R6 zero value");
        t_send(8'b0001_0000, 3, "R6 nothing kept");
        t_send(8'b1100_0000, 0, "R6 zero request");
        t_illegal();
        t_overflow();
        t_gaps();
        t_send(8'b0110_1000, 7, "after manual");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule